// File: doc/BRIEF.md
# Two-Phase Clause 45 Management Master

This block turns a handful of host-written operands into complete Clause 45 management transactions on an MDC/MDIO pair. The host fills in an operation code, a 5-bit port address, a 5-bit device type, a register address and a write word, then pulses `start`. The block always sends two frames back to back. The first is an address frame that sets the register pointer inside the selected device. The second is the write, read or read-with-increment frame the host asked for.

MDC is derived from the system clock through a divider that software can set. MDIO leaves the block as a data/enable pair, so an external pad can resolve it to a tri-state line. During read frames the block lets go of the line for the turnaround and data bits. It shifts in the sixteen bits the PHY returns. If nothing answers, the pull-up gives 0xFFFF, and the transaction ends on the same schedule as any other.

Top module: `c45_mgmt_master`

## Requirements
- R1: After reset `busy`, `done`, `mdio_oe` and `mdc` are low and `rd_data` is 0x0000. `mdio_oe` is low in every cycle in which `busy` is low.
- R2: A write through `reg_we` lands in the operand chosen by `reg_sel`: 0 selects the operation (bits 1:0), 1 the port (bits 4:0), 2 the device type (bits 4:0), 3 the register address and 4 the write word. Writes made while `busy` is high are ignored.
- R3: Each started transaction sends exactly two frames. The first carries opcode 00 and the register address in its data field. The second carries the host opcode: 01 write, 11 read, 10 read with post-increment.
- R4: Every frame begins with 33 MDC cycles in which MDIO is high.
- R5: After the preamble, each frame carries these fields, each sent MSB first: start code 00, the 2-bit opcode, the 5-bit port, the 5-bit device type, and turnaround. Turnaround is driven as 1 then 0 on address and write frames. The 16 data bits follow. On a write frame the data field is the write word.
- R6: On read and read-increment frames, `mdio_oe` is low from the first turnaround bit through the last data bit. The 16 data bits are sampled on rising MDC edges, MSB first, and appear on `rd_data` when the transaction ends.
- R7: A read that no device answers returns 0xFFFF and completes after the same number of MDC cycles as an answered read.
- R8: MDC has a period of 2*(`mdc_div`+1) system clocks and idles low. MDIO output data changes only in the cycle where MDC falls.
- R9: `busy` is high from the cycle after an accepted `start` until the final falling MDC edge. At that point `done` is high for exactly one cycle while `busy` is low. `rd_data` holds its value while `busy` is high and changes only at the end of a read-type transaction.
- R10: A `start` pulse given while `busy` is high is ignored, so each transaction produces exactly 130 rising MDC edges.
- R11: The device-type field is carried unchanged for any value from 0x00 to 0x1F, including 0x1E and 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host operand write strobe |
| reg_sel | input | 3 | Operand selector |
| reg_wdata | input | 16 | Operand write value |
| start | input | 1 | Launch a two-frame transaction |
| mdc_div | input | DIV_W | Half-period of MDC minus one, in system clocks |
| mdio_i | input | 1 | Resolved MDIO line level |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last captured read value |

## Verification
The bench builds the block with the default 33-bit preamble and `DIV_W` of 4. It changes `mdc_div` between 0, 1 and 3 from one transaction to the next. A divider of 0 makes MDC edges fall on consecutive system clocks, so the drive-on-fall and sample-on-rise ordering meets its tightest case. The other two values confirm that the MDC period scales. The PHY responder answers device types 1, 3 and 7 and stays silent for all others, which reaches the unanswered-read path with 0x1E. A stray start and operand write in the middle of a transaction reach the ignore rules.

// File: rtl/c45_pkg.sv
package c45_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RDINC = 2'b10,
        OP_READ  = 2'b11
    } c45_op_e;

    localparam int HDR_BITS  = 16;
    localparam int DATA_BITS = 16;
    localparam int BODY_BITS = HDR_BITS + DATA_BITS;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] addr;
        logic [15:0] wdata;
    } c45_host_t;

endpackage

// File: rtl/c45_mdc_gen.sv
module c45_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!en) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (s_q.cnt == div) begin
            s_d.cnt  = '0;
            s_d.mdc  = ~s_q.mdc;
            rise_stb = ~s_q.mdc;
            fall_stb = s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

    // R8
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);

endmodule

// File: rtl/c45_frame_seq.sv
module c45_frame_seq
    import c45_pkg::*;
#(
    parameter int PRE_LEN = 33
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  c45_host_t   host,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdc,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);

    localparam int FRAME_LEN  = PRE_LEN + BODY_BITS;
    localparam int IDX_W      = $clog2(FRAME_LEN + 1);
    localparam int TA_FIRST   = PRE_LEN + HDR_BITS - 2;
    localparam int DATA_FIRST = PRE_LEN + HDR_BITS;

    typedef struct packed {
        logic             busy;
        logic             second;
        logic [IDX_W-1:0] idx;
        logic             mo;
        logic             moe;
        logic [15:0]      shreg;
        logic [15:0]      rd;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    logic [31:0] word0, word1;
    logic        rd1, rd_cur;
    logic [1:0]  drv;

    // returns {oe, value} for frame bit n
    function automatic logic [1:0] drive_at(input logic rdf, input logic [31:0] w,
                                            input logic [IDX_W-1:0] n);
        logic [1:0] r;
        int         k;
        if (int'(n) < PRE_LEN) begin
            r = 2'b11;
        end else begin
            k = int'(n) - PRE_LEN;
            if (rdf && k >= TA_FIRST - PRE_LEN) r = 2'b01;
            else                                r = {1'b1, w[5'(31 - k)]};
        end
        return r;
    endfunction

    always_comb begin
        word0  = {2'b00, OP_ADDR, host.port, host.dev, 2'b10, host.addr};
        word1  = {2'b00, host.op, host.port, host.dev, 2'b10,
                  host.op[1] ? 16'hFFFF : host.wdata};
        rd1    = host.op[1];
        rd_cur = s_q.second & rd1;
        drv    = 2'b00;

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                drv        = drive_at(1'b0, word0, '0);
                s_d.busy   = 1'b1;
                s_d.second = 1'b0;
                s_d.idx    = '0;
                s_d.moe    = drv[1];
                s_d.mo     = drv[0];
            end
        end else begin
            if (rise_stb && rd_cur && int'(s_q.idx) >= DATA_FIRST) begin
                s_d.shreg = {s_q.shreg[14:0], mdio_i};
            end
            if (fall_stb) begin
                if (int'(s_q.idx) == FRAME_LEN - 1) begin
                    if (!s_q.second) begin
                        drv        = drive_at(rd1, word1, '0);
                        s_d.second = 1'b1;
                        s_d.idx    = '0;
                        s_d.moe    = drv[1];
                        s_d.mo     = drv[0];
                    end else begin
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.moe  = 1'b0;
                        s_d.mo   = 1'b1;
                        if (rd1) s_d.rd = s_q.shreg;
                    end
                end else begin
                    drv     = s_q.second ? drive_at(rd1, word1, s_q.idx + 1'b1)
                                         : drive_at(1'b0, word0, s_q.idx + 1'b1);
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.moe = drv[1];
                    s_d.mo  = drv[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.mo <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign mdio_o  = s_q.mo;
    assign mdio_oe = s_q.moe;
    assign rd_data = s_q.rd;

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    // R8
    mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(rd_data));

endmodule

// File: rtl/c45_mgmt_master.sv
module c45_mgmt_master
    import c45_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [15:0]      reg_wdata,
    input  logic             start,
    input  logic [DIV_W-1:0] mdc_div,
    input  logic             mdio_i,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data
);

    c45_host_t h_d, h_q;
    logic      rise_stb, fall_stb;

    always_comb begin
        h_d = h_q;
        if (reg_we && !busy) begin
            case (reg_sel)
                3'd0:    h_d.op    = reg_wdata[1:0];
                3'd1:    h_d.port  = reg_wdata[4:0];
                3'd2:    h_d.dev   = reg_wdata[4:0];
                3'd3:    h_d.addr  = reg_wdata;
                3'd4:    h_d.wdata = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    c45_mdc_gen #(.DIV_W(DIV_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .div      (mdc_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    c45_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .host     (h_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    // R2
    host_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(h_q));

endmodule

// File: tb/c45_mgmt_master_test.sv
`timescale 1ns/1ps
module c45_mgmt_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        start = 1'b0;
    logic [3:0]  mdc_div = 4'd1;
    logic        mdc, mdio_o, mdio_oe, busy, done;
    logic [15:0] rd_data;
    logic        phy_oe = 1'b0, phy_d = 1'b1;
    logic        mdio_line;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);

    c45_mgmt_master #(.DIV_W(4), .PRE_LEN(33)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .start(start), .mdc_div(mdc_div),
        .mdio_i(mdio_line), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0]  op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] rd_exp;
        int          div;
    } txn_t;

    txn_t sb[$];

    logic    cap[0:129];
    logic    oecap[0:129];
    int      rc = 0;
    realtime t_r0, t_r1;

    always @(posedge mdc) begin
        #1;
        if (rc < 130) begin
            cap[rc]   = mdio_line;
            oecap[rc] = mdio_oe;
        end
        if (rc == 0) t_r0 = $realtime;
        if (rc == 1) t_r1 = $realtime;
        rc++;
    end

    // PHY responder: answers device types 1, 3, 7
    int          pn, pb;
    logic [4:0]  pdev;
    logic [15:0] paddr, pval;
    always @(negedge mdc) begin
        #1;
        pn = rc % 65;
        pb = (rc / 65) * 65;
        phy_oe = 1'b0;
        if (rc < 130 && pb == 65 && pn >= 48 && cap[pb+35] === 1'b1) begin
            pdev = {cap[pb+42], cap[pb+43], cap[pb+44], cap[pb+45], cap[pb+46]};
            for (int i = 0; i < 16; i++) paddr[15-i] = cap[49+i];
            pval = {pdev[3:0], paddr[11:0]};
            if (pdev == 5'd1 || pdev == 5'd3 || pdev == 5'd7) begin
                phy_oe = 1'b1;
                phy_d  = (pn == 48) ? 1'b0 : pval[64-pn];
            end
        end
    end

    function automatic logic exp_bit(input logic [1:0] op, input logic [4:0] port,
                                     input logic [4:0] dev, input logic [15:0] data,
                                     input int i);
        logic [31:0] w;
        w = {2'b00, op, port, dev, 2'b10, data};
        if (i < 33) return 1'b1;
        return w[31-(i-33)];
    endfunction

    // monitor: compares finished transactions with scoreboard
    logic [15:0] last_rd = 16'h0000;
    always @(negedge clk) begin
        if (done) begin
            txn_t t;
            int   bad0, bad1, pre, oebad, lim;
            t = sb.pop_front();
            bad0 = 0; bad1 = 0; pre = 0; oebad = 0;
            lim = t.op[1] ? 46 : 64;
            for (int i = 0; i < 65; i++) begin
                if (cap[i] !== exp_bit(2'b00, t.port, t.dev, t.addr, i)) bad0++;
                if (i <= lim && cap[65+i] !== exp_bit(t.op, t.port, t.dev, t.wdata, i)) bad1++;
                if (t.op[1] && i >= 47 && oecap[65+i] !== 1'b0) oebad++;
                if (i < 33 && cap[i] === 1'b1 && cap[65+i] === 1'b1) pre++;
            end
            chk("R3 address frame", bad0, 0);
            chk("R5 second frame fields", bad1, 0);
            chk("R4 preamble ones", pre, 33);
            chk("R10 mdc rises", rc, 130);
            chk("R8 mdc period", int'((t_r1 - t_r0) * 10), (t.div + 1) * 100);
            if (t.op[1]) begin
                chk("R6 line released", oebad, 0);
                chk("R6 R7 rd_data", rd_data, t.rd_exp);
                last_rd = t.rd_exp;
            end else begin
                chk("R9 rd_data kept", rd_data, last_rd);
            end
            chk("R1 released at end", mdio_oe, 1'b0);
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run(input logic [1:0] op, input logic [4:0] port, input logic [4:0] dev,
                       input logic [15:0] addr, input logic [15:0] wdata, input int div,
                       input bit write_regs, input bit stray);
        txn_t t;
        t.op = op; t.port = port; t.dev = dev; t.addr = addr; t.wdata = wdata; t.div = div;
        t.rd_exp = (dev == 5'd1 || dev == 5'd3 || dev == 5'd7) ? {dev[3:0], addr[11:0]} : 16'hFFFF;
        mdc_div = 4'(div);
        if (write_regs) begin
            wr(3'd0, {14'd0, op});
            wr(3'd1, {11'd0, port});
            wr(3'd2, {11'd0, dev});
            wr(3'd3, addr);
            wr(3'd4, wdata);
        end
        sb.push_back(t);
        rc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 busy after start", busy, 1'b1);
        if (stray) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 16'h001F;
            @(negedge clk);
            start = 1'b0; reg_we = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        chk("R9 done one cycle", {done, busy}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {busy, done, mdio_oe, mdc}, 4'b0000);
        chk("R1 reset rd_data", rd_data, 16'h0000);

        run(2'b01, 5'h0C, 5'h01, 16'h0010, 16'hA5C3, 1, 1, 0);  // R3 R5 write
        run(2'b11, 5'h0C, 5'h07, 16'h0000, 16'h0000, 1, 1, 0);  // R6 read
        run(2'b11, 5'h0C, 5'h1E, 16'h8001, 16'h0000, 1, 1, 0);  // R7 R11 no answer
        run(2'b10, 5'h03, 5'h03, 16'h0123, 16'h0000, 0, 1, 0);  // R6 read-increment, fastest mdc
        run(2'b01, 5'h15, 5'h1F, 16'hFFFF, 16'h0001, 3, 1, 1);  // R10 R2 stray start/write
        run(2'b01, 5'h15, 5'h1F, 16'hFFFF, 16'h0001, 3, 0, 0);  // R2 port kept at 0x15
        run(2'b11, 5'h00, 5'h00, 16'h0004, 16'h0000, 0, 1, 0);  // R11 device 0

        chk("R9 scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule